// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block is the host side of a two-wire station-management link. Software reaches it through a small 32-bit register port made of a write strobe, a word address and a read-back bus. It programs a clock divisor and an enable bit, loads a 16-bit value for writes, and starts one Clause 22 frame by writing a control word that carries the PHY address, the register address, a read/write select and a start bit. The block generates MDC, drives or releases the data line through an output value and an output enable, and captures the 16 bits a PHY returns on a read.

A ready flag in the control word tells software when a new frame may be started. A start request made while ready is low has no effect. Clearing the enable bit stops MDC, abandons any frame in progress and releases the data line. The register port has no back-pressure: writes take effect at the clock edge where the strobe is high, and read-back data is a combinational function of the address.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the four registers read back as zero, `mdc` is low, `mdio_oe` is low and the ready bit is 0.
- R2: While the enable bit (config bit 16) is 0, `mdc` stays low and ready stays 0. Clearing it during a frame abandons the frame, and `mdio_oe` is low from the second clock edge after the write.
- R3: With enable set and divisor value D (config bits [7:0]), MDC has a period of 2*(D+1) host clocks and stays high for D+1 of them.
- R4: Ready (control bit 31) is 1 exactly when the block is enabled and no frame is in progress. It reads 0 in the cycle after a start is accepted and returns to 1 once the frame's last bit has finished.
- R5: A control write with the start bit (bit 15) set is accepted only while ready is 1. Otherwise it starts no frame and leaves the stored PHY address, register address and read select unchanged.
- R6: A write frame (control bit 14 = 0) puts 64 bits on the data line, sampled on MDC rising edges, with the output enabled throughout: 32 ones, 01, opcode 01, the PHY address (control bits [4:0]) MSB first, the register address (control bits [12:8]) MSB first, turnaround 10, then the write-data register's 16 bits, MSB first.
- R7: A read frame (control bit 14 = 1) drives 32 ones, 01, opcode 10 and the two addresses. It then holds `mdio_oe` low for the two turnaround bits and the 16 data bits.
- R8: The block changes `mdio_o` only on MDC falling edges. On a read it samples `mdio_i` on MDC rising edges.
- R9: After a read frame, the read-data register holds the 16 sampled bits in [15:0], first bit in bit 15, with bits [31:16] zero. The value is in place when ready returns to 1.
- R10: Register offsets are 0x0 config, 0x4 control, 0x8 write data and 0xC read data. Write data reads back in bits [15:0]. The start bit always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe, one write per high cycle |
| bus_addr | input | 4 | Byte address of the register (word aligned) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read-back of the register at `bus_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value while driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Sampled data line |

## Verification
The properties assume that reset is held low before the first clock edge. They also assume that the PHY side changes `mdio_i` only while MDC is low. The bench PHY model updates `mdio_i` on MDC falling edges and leaves it constant otherwise. The properties also assume that software changes the divisor only while no frame is in progress. The bench rewrites the config register only when ready is high, or when it deliberately clears enable to abandon a frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS   = 64;
  localparam int DATA_BITS    = 16;
  localparam int RD_DRIVEN    = 46;
  localparam int DATA_FIRST   = 48;
  localparam int ADDR_W       = 4;

  localparam logic [1:0] SLOT_CFG   = 2'd0;
  localparam logic [1:0] SLOT_CTRL  = 2'd1;
  localparam logic [1:0] SLOT_WDATA = 2'd2;
  localparam logic [1:0] SLOT_RDATA = 2'd3;

  localparam int CFG_EN_BIT  = 16;
  localparam int CTL_PHY_LSB = 0;
  localparam int CTL_REG_LSB = 8;
  localparam int CTL_RD_BIT  = 14;
  localparam int CTL_GO_BIT  = 15;
  localparam int CTL_RDY_BIT = 31;

  typedef enum logic [1:0] {ENG_IDLE, ENG_ARM, ENG_SHIFT} eng_state_e;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_req_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
    return {32'hFFFF_FFFF, 2'b01, (r.rd ? 2'b10 : 2'b01), r.phy, r.regad,
            (r.rd ? 2'b11 : 2'b10), (r.rd ? 16'hFFFF : r.wdata)};
  endfunction
endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
module mdio_mgmt_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             hit;

  assign hit       = en && (cnt_q >= div);
  assign rise_tick = hit && !mdc_q;
  assign fall_tick = hit && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc_q);
  // R2
  mdc_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(en));
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 start,
  input  mdio_req_t            req,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [DATA_BITS-1:0] result
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] REL_IDX   = IDX_W'(RD_DRIVEN);
  localparam logic [IDX_W-1:0] FIRST_DAT = IDX_W'(DATA_FIRST);

  eng_state_e              state_q;
  logic [FRAME_BITS-1:0]   frame_q;
  logic [IDX_W-1:0]        idx_q;
  logic [IDX_W-1:0]        idx_nxt;
  logic                    rd_q;
  logic                    mdo_q;
  logic                    oe_q;
  logic [DATA_BITS-1:0]    cap_q;
  logic [DATA_BITS-1:0]    res_q;

  assign idx_nxt = idx_q + 1'b1;
  assign busy    = (state_q != ENG_IDLE);
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
  assign result  = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      frame_q <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      mdo_q   <= 1'b1;
      oe_q    <= 1'b0;
      cap_q   <= '0;
      res_q   <= '0;
    end else if (!en) begin
      state_q <= ENG_IDLE;
      mdo_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (start) begin
            frame_q <= build_frame(req);
            rd_q    <= req.rd;
            state_q <= ENG_ARM;
          end
        end
        ENG_ARM: begin
          if (fall_tick) begin
            mdo_q   <= frame_q[FRAME_BITS-1];
            oe_q    <= 1'b1;
            idx_q   <= '0;
            state_q <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (rise_tick && rd_q && (idx_q >= FIRST_DAT))
            cap_q <= {cap_q[DATA_BITS-2:0], mdio_i};
          if (fall_tick) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ENG_IDLE;
              mdo_q   <= 1'b1;
              oe_q    <= 1'b0;
              if (rd_q) res_q <= cap_q;
            end else begin
              idx_q   <= idx_nxt;
              frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
              mdo_q   <= frame_q[FRAME_BITS-2];
              oe_q    <= !(rd_q && (idx_nxt >= REL_IDX));
            end
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_SHIFT && rd_q && idx_q >= REL_IDX) |-> !oe_q);
  // R8
  tx_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdo_q) && $past(en)) |-> $past(fall_tick));
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state_q != ENG_IDLE));
  // R2
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!oe_q && state_q == ENG_IDLE));
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  input  logic                 busy,
  input  logic [DATA_BITS-1:0] result,
  output logic                 en,
  output logic [DIV_W-1:0]     div,
  output logic                 start,
  output mdio_req_t            req,
  output logic [31:0]          rdata
);
  logic [DIV_W-1:0]     div_q;
  logic                 en_q;
  logic [4:0]           phy_q;
  logic [4:0]           reg_q;
  logic                 rd_q;
  logic [DATA_BITS-1:0] wd_q;
  logic                 ready;
  logic [1:0]           slot;

  assign slot  = addr[3:2];
  assign ready = en_q && !busy;
  assign start = wr_en && (slot == SLOT_CTRL) && wdata[CTL_GO_BIT] && ready;
  assign en    = en_q;
  assign div   = div_q;

  assign req.rd    = wdata[CTL_RD_BIT];
  assign req.phy   = wdata[CTL_PHY_LSB +: 5];
  assign req.regad = wdata[CTL_REG_LSB +: 5];
  assign req.wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      en_q  <= 1'b0;
      phy_q <= '0;
      reg_q <= '0;
      rd_q  <= 1'b0;
      wd_q  <= '0;
    end else if (wr_en) begin
      unique case (slot)
        SLOT_CFG: begin
          div_q <= wdata[DIV_W-1:0];
          en_q  <= wdata[CFG_EN_BIT];
        end
        SLOT_CTRL: begin
          if (start) begin
            phy_q <= wdata[CTL_PHY_LSB +: 5];
            reg_q <= wdata[CTL_REG_LSB +: 5];
            rd_q  <= wdata[CTL_RD_BIT];
          end
        end
        SLOT_WDATA: wd_q <= wdata[DATA_BITS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (slot)
      SLOT_CFG: begin
        rdata[DIV_W-1:0]  = div_q;
        rdata[CFG_EN_BIT] = en_q;
      end
      SLOT_CTRL: begin
        rdata[CTL_PHY_LSB +: 5] = phy_q;
        rdata[CTL_REG_LSB +: 5] = reg_q;
        rdata[CTL_RD_BIT]       = rd_q;
        rdata[CTL_RDY_BIT]      = ready;
      end
      SLOT_WDATA: rdata[DATA_BITS-1:0] = wd_q;
      default:    rdata[DATA_BITS-1:0] = result;
    endcase
  end

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && slot == SLOT_CTRL && !ready) |=> $stable({phy_q, reg_q, rd_q}));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic                 en;
  logic [DIV_W-1:0]     div;
  logic                 start;
  mdio_req_t            req;
  logic                 busy;
  logic [DATA_BITS-1:0] result;
  logic                 rise_tick;
  logic                 fall_tick;

  mdio_mgmt_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .busy(busy), .result(result), .en(en), .div(div),
    .start(start), .req(req), .rdata(bus_rdata)
  );

  mdio_mgmt_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_mgmt_engine u_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .req(req),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .result(result)
  );
endmodule

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe = '0;
  int          fc = 0;
  int          frames_done = 0;
  logic [15:0] phy_val = 16'h0;
  logic        phy_rst = 1'b0;
  int          viol = 0;
  logic        prev_mdo = 1'b1;

  always #2 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: record the line on MDC rising edges
  always @(posedge mdc or posedge phy_rst) begin
    if (phy_rst) fc = 0;
    else if (fc != 0 || mdio_oe) begin
      cap_bits = {cap_bits[62:0], mdio_o};
      cap_oe   = {cap_oe[62:0], mdio_oe};
      fc++;
      if (fc == 64) begin fc = 0; frames_done++; end
    end
  end

  // PHY model: drive read data on MDC falling edges
  always @(negedge mdc or posedge phy_rst) begin
    if (phy_rst) mdio_i <= 1'b1;
    else mdio_i <= (fc >= 48 && fc < 64) ? phy_val[63 - fc] : 1'b1;
  end

  // R8 monitor: a change of mdio_o must coincide with MDC going low
  always @(negedge clk) begin
    if (rst_n && mdio_o !== prev_mdo && mdc) viol++;
    prev_mdo = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_ready(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      bus_read(4'h4, v);
      if (v[31]) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      bus_read(4'(a * 4), v);
      chk(v == 32'h0, "R1 register reset value", v, 0);
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe after reset", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    bit seen = 0;
    bus_write(4'h4, 32'h0000_8000 | 32'h0000_0301);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe) seen = 1;
    end
    chk(!seen, "R2 mdc low and no frame while disabled", seen, 0);
    bus_read(4'h4, v);
    chk(v == 32'h0, "R5 start ignored while disabled, ready low", v, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    bus_write(4'h0, 32'h0001_0002);
    bus_read(4'h4, v);
    chk(v[31] == 1'b1, "R4 ready after enable", v[31], 1);
    bus_read(4'h0, v);
    chk(v == 32'h0001_0002, "R10 config readback", v, 32'h0001_0002);
  endtask

  task automatic measure(input int d);
    time t1, t2, t3;
    @(posedge mdc); t1 = $time;
    @(negedge mdc); t2 = $time;
    @(posedge mdc); t3 = $time;
    chk((t3 - t1) == 4 * 2 * (d + 1), "R3 mdc period", (t3 - t1) / 4, 2 * (d + 1));
    chk((t2 - t1) == 4 * (d + 1), "R3 mdc high time", (t2 - t1) / 4, d + 1);
  endtask

  task automatic t_period();
    measure(2);
    bus_write(4'h0, 32'h0001_0000);
    measure(0);
    bus_write(4'h0, 32'h0001_0005);
    measure(5);
    bus_write(4'h0, 32'h0001_0002);
  endtask

  task automatic t_write_frame();
    logic [31:0] v;
    logic [63:0] exp;
    bit ok;
    int f0 = frames_done;
    bus_write(4'h8, 32'h0000_A5C3);
    bus_read(4'h8, v);
    chk(v == 32'h0000_A5C3, "R10 write data readback", v, 32'h0000_A5C3);
    bus_write(4'h4, 32'h0000_8B13);
    bus_read(4'h4, v);
    chk(v[31] == 1'b0, "R4 ready low during frame", v[31], 0);
    chk(v[15] == 1'b0 && v[12:0] == 13'h0B13, "R10 control readback, start bit reads 0", v, 32'h0B13);
    wait_ready(ok);
    chk(ok, "R4 ready returns after frame", ok, 1);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0B, 2'b10, 16'hA5C3};
    chk(frames_done == f0 + 1, "R6 one write frame", frames_done - f0, 1);
    chk(cap_bits == exp, "R6 write frame bits", cap_bits, exp);
    chk(cap_oe == '1, "R6 line driven for all bits", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(viol == 0, "R8 mdio_o changes only on MDC fall", viol, 0);
  endtask

  task automatic t_read_frame(input logic [4:0] p, input logic [4:0] r, input logic [15:0] val);
    logic [31:0] v;
    logic [45:0] hdr;
    logic [63:0] oe_exp;
    bit ok;
    phy_val = val;
    bus_write(4'h4, 32'h0000_C000 | {19'h0, r, 3'h0, p});
    wait_ready(ok);
    chk(ok, "R4 ready returns after read", ok, 1);
    hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    chk(cap_bits[63:18] == hdr, "R7 read header bits", cap_bits[63:18], hdr);
    oe_exp = {{46{1'b1}}, 18'b0};
    chk(cap_oe == oe_exp, "R7 released for turnaround and data", cap_oe, oe_exp);
    bus_read(4'hC, v);
    chk(v == {16'h0, val}, "R9 read data register", v, {16'h0, val});
    chk(viol == 0, "R8 no mid-high changes on read", viol, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    logic [63:0] exp;
    bit ok;
    int f0 = frames_done;
    bus_write(4'h8, 32'h0000_1234);
    bus_write(4'h4, 32'h0000_8502);
    repeat (20) @(negedge clk);
    bus_write(4'h4, 32'h0000_DF1F);
    bus_read(4'h4, v);
    chk(v[14:0] == 15'h0502, "R5 control fields kept while busy", v[14:0], 15'h0502);
    wait_ready(ok);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h02, 5'h05, 2'b10, 16'h1234};
    chk(cap_bits == exp, "R5 frame unaffected by ignored start", cap_bits, exp);
    repeat (300) @(negedge clk);
    chk(frames_done == f0 + 1, "R5 no second frame", frames_done - f0, 1);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    bus_write(4'h4, 32'h0000_8101);
    repeat (100) @(negedge clk);
    bus_write(4'h0, 32'h0000_0002);
    @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2 abort stops mdc and releases line", {mdc, mdio_oe}, 0);
    bus_read(4'h4, v);
    chk(v[31] == 1'b0, "R2 ready low after disable", v[31], 0);
    phy_rst = 1'b1; #1 phy_rst = 1'b0;
    bus_write(4'h0, 32'h0001_0002);
    bus_read(4'h4, v);
    chk(v[31] == 1'b1, "R4 ready after re-enable", v[31], 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_enable();
    t_period();
    t_write_frame();
    t_read_frame(5'h05, 5'h1F, 16'h3C5A);
    t_read_frame(5'h1A, 5'h00, 16'h8001);
    t_busy_ignore();
    t_abort();
    t_read_frame(5'h11, 5'h0E, 16'hF00F);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule